// File: doc/BRIEF.md
# UDP Console Frame Builder

This block assembles a complete Ethernet frame that carries an IPv4/UDP datagram from a stream of payload bytes. Bytes are appended one per cycle into an internal payload store and are placed after a fixed 42-byte header region. The block keeps a running count of the appended bytes.

A send command starts the frame. The block captures the addressing inputs and derives both length fields from the byte count. It computes the IPv4 header checksum in one extra cycle, then streams the frame one byte per accepted beat on a valid/ready/last interface. Frames shorter than the minimum are padded with zero bytes. After the last byte is accepted, the count returns to zero, so the next payload again starts at byte 42.

The Ethernet CRC is not part of this block. The UDP checksum field is always sent as zero.

Top module: `udp_frame_builder`

## Requirements
- R1: The fixed header bytes are fixed at these positions. Bytes 6-11 are 02 00 00 C0 FF EE and bytes 12-13 are 08 00. Byte 14 is 45 and byte 15 is 00. Bytes 18-19 are 00 00 and bytes 20-21 are 40 00. Byte 22 is 40 and byte 23 is 11. Bytes 34-37 are 1A 0B 1A 0A and bytes 40-41 are 00 00.
- R2: Bytes 0-5 carry the destination MAC, most significant byte first. Bytes 26-29 carry the source IP and bytes 30-33 carry the destination IP. All three values are sampled in the cycle the send is accepted, and later input changes do not affect a frame in flight.
- R3: For a payload count L, bytes 16-17 hold 28+L and bytes 38-39 hold 8+L, both big-endian.
- R4: Bytes 24-25 hold the big-endian ones'-complement of the ones'-complement sum of the ten 16-bit words in bytes 14-33, with the checksum field taken as zero and carries folded back in.
- R5: Payload bytes appear from byte 42 onward, in the order they were appended.
- R6: The frame length is 42+L, raised to MIN_FRAME (64) when it is shorter. Every byte past the payload is 00.
- R7: A byte is transferred when tx_valid and tx_ready are both high. While tx_ready is low, tx_data and tx_last hold their values. tx_last is high only on the final byte.
- R8: While busy is high, appends and sends are ignored. An append presented in the same cycle as an accepted send is also ignored.
- R9: Appends beyond MAX_PAYLOAD bytes are dropped and set ovf. The ovf flag stays set until the frame completes.
- R10: When the last byte is accepted, busy drops in the next cycle, and the count and ovf clear.
- R11: After reset, tx_valid, busy and ovf are low and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| app_valid | input | 1 | Append one payload byte this cycle |
| app_data | input | 8 | Payload byte |
| send | input | 1 | Start building and streaming a frame |
| cfg_dst_mac | input | 48 | Destination MAC address |
| cfg_src_ip | input | 32 | Source IPv4 address |
| cfg_dst_ip | input | 32 | Destination IPv4 address |
| tx_ready | input | 1 | Sink accepts the current byte |
| tx_valid | output | 1 | Frame byte present |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| busy | output | 1 | A frame is being built or streamed |
| ovf | output | 1 | Payload overflow seen since the last frame |

## Verification
The bench builds the block with MAX_PAYLOAD set to 30 and MIN_FRAME kept at 64. With this setting, overflow takes only a few dozen appends. A full payload gives a 72-byte frame, which needs no padding. An empty or short payload exercises the zero padding. Backpressure patterns, rejected appends and sends during streaming, and mid-frame changes of the addressing inputs are all judged from the bytes that leave the block.

// File: rtl/udpfb_pkg.sv
package udpfb_pkg;
   localparam int HDR_BYTES   = 42;
   localparam int IP_LEN_OVH  = 28;
   localparam int UDP_LEN_OVH = 8;
   localparam logic [47:0] SRC_MAC      = 48'h0200_00C0_FFEE;
   localparam logic [15:0] ETH_TYPE_IP  = 16'h0800;
   localparam logic [7:0]  IP_VIHL      = 8'h45;
   localparam logic [15:0] IP_FRAG      = 16'h4000;
   localparam logic [7:0]  IP_TTL       = 8'h40;
   localparam logic [7:0]  IP_PROTO_UDP = 8'h11;
   localparam logic [15:0] UDP_SPORT    = 16'h1A0B;
   localparam logic [15:0] UDP_DPORT    = 16'h1A0A;

   typedef logic [HDR_BYTES-1:0][7:0] hdr_bytes_t;
   typedef enum logic [1:0] {SEQ_IDLE, SEQ_CALC, SEQ_STREAM} seq_state_t;

   function automatic logic [15:0] ones_fold(input logic [19:0] s);
      logic [16:0] t;
      t = {1'b0, s[15:0]} + {13'd0, s[19:16]};
      return t[15:0] + {15'd0, t[16]};
   endfunction
endpackage

// File: rtl/udpfb_buf.sv
module udpfb_buf
   import udpfb_pkg::*;
#(
   parameter int MAX_PAYLOAD = 1472,
   parameter int CNT_W       = $clog2(MAX_PAYLOAD + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             app_valid,
   input  logic [7:0]       app_data,
   input  logic             block,
   input  logic             clr,
   input  logic [CNT_W-1:0] rd_addr,
   output logic [CNT_W-1:0] count,
   output logic             ovf,
   output logic [7:0]       rd_data
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PAYLOAD);

   generate
      if (MAX_PAYLOAD < 1 || MAX_PAYLOAD > 1472) begin : g_bad_depth
         $error("udpfb_buf: MAX_PAYLOAD out of range");
      end
   endgenerate

   logic [7:0]       mem [MAX_PAYLOAD];
   logic [CNT_W-1:0] count_q;
   logic             ovf_q;
   logic             try_app, take_app;

   assign try_app  = app_valid && !block;
   assign take_app = try_app && (count_q < CNT_MAX);

   always_ff @(posedge clk) begin
      if (take_app) mem[count_q] <= app_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else if (clr) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         if (take_app) count_q <= count_q + 1'b1;
         if (try_app && count_q == CNT_MAX) ovf_q <= 1'b1;
      end
   end

   assign rd_data = (rd_addr < CNT_MAX) ? mem[rd_addr] : 8'h00;
   assign count   = count_q;
   assign ovf     = ovf_q;

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_MAX);
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr) |=> ovf_q);
   p_count_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (block && !clr) |=> $stable(count_q));
endmodule

// File: rtl/udpfb_hdr.sv
module udpfb_hdr
   import udpfb_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             calc_en,
   input  logic             clr,
   input  logic [CNT_W-1:0] plen,
   input  logic [47:0]      dst_mac,
   input  logic [31:0]      src_ip,
   input  logic [31:0]      dst_ip,
   output hdr_bytes_t       hdr
);
   generate
      if (CNT_W < 1 || CNT_W > 15) begin : g_bad_cnt
         $error("udpfb_hdr: CNT_W out of range");
      end
   endgenerate

   logic [15:0] ip_len, udp_len, csum_q;
   logic [19:0] wsum, vsum;
   logic        csum_vld_q;

   assign ip_len  = 16'(plen) + 16'(IP_LEN_OVH);
   assign udp_len = 16'(plen) + 16'(UDP_LEN_OVH);

   always_comb begin
      wsum = 20'({IP_VIHL, 8'h00}) + 20'(ip_len) + 20'(IP_FRAG)
           + 20'({IP_TTL, IP_PROTO_UDP})
           + 20'(src_ip[31:16]) + 20'(src_ip[15:0])
           + 20'(dst_ip[31:16]) + 20'(dst_ip[15:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csum_q     <= '0;
         csum_vld_q <= 1'b0;
      end else if (clr) begin
         csum_vld_q <= 1'b0;
      end else if (calc_en) begin
         csum_q     <= ~ones_fold(wsum);
         csum_vld_q <= 1'b1;
      end
   end

   always_comb begin
      hdr = '0;
      for (int i = 0; i < 6; i++) begin
         hdr[i]     = dst_mac[47-8*i -: 8];
         hdr[6 + i] = SRC_MAC[47-8*i -: 8];
      end
      hdr[12] = ETH_TYPE_IP[15:8];
      hdr[13] = ETH_TYPE_IP[7:0];
      hdr[14] = IP_VIHL;
      hdr[16] = ip_len[15:8];
      hdr[17] = ip_len[7:0];
      hdr[20] = IP_FRAG[15:8];
      hdr[21] = IP_FRAG[7:0];
      hdr[22] = IP_TTL;
      hdr[23] = IP_PROTO_UDP;
      hdr[24] = csum_q[15:8];
      hdr[25] = csum_q[7:0];
      for (int i = 0; i < 4; i++) begin
         hdr[26 + i] = src_ip[31-8*i -: 8];
         hdr[30 + i] = dst_ip[31-8*i -: 8];
      end
      hdr[34] = UDP_SPORT[15:8];
      hdr[35] = UDP_SPORT[7:0];
      hdr[36] = UDP_DPORT[15:8];
      hdr[37] = UDP_DPORT[7:0];
      hdr[38] = udp_len[15:8];
      hdr[39] = udp_len[7:0];
   end

   // Summing the emitted IPv4 header, checksum included, must give all ones.
   always_comb begin
      vsum = '0;
      for (int i = 0; i < 10; i++) vsum = vsum + 20'({hdr[14+2*i], hdr[15+2*i]});
   end

   p_csum_verify_r4: assert property (@(posedge clk) disable iff (!rst_n)
      csum_vld_q |-> ones_fold(vsum) == 16'hFFFF);
endmodule

// File: rtl/udpfb_seq.sv
module udpfb_seq
   import udpfb_pkg::*;
#(
   parameter int MAX_PAYLOAD = 1472,
   parameter int MIN_FRAME   = 64,
   parameter int CNT_W       = $clog2(MAX_PAYLOAD + 1),
   parameter int IDX_W       = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             send,
   input  logic [CNT_W-1:0] plen,
   input  hdr_bytes_t       hdr,
   input  logic [7:0]       rd_data,
   input  logic             tx_ready,
   output logic             busy,
   output logic             calc_en,
   output logic             done,
   output logic [CNT_W-1:0] rd_addr,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last
);
   generate
      if (MIN_FRAME <= HDR_BYTES) begin : g_bad_min
         $error("udpfb_seq: MIN_FRAME must exceed the header length");
      end
      if ((1 << IDX_W) <= HDR_BYTES + MAX_PAYLOAD || (1 << IDX_W) <= MIN_FRAME) begin : g_bad_idx
         $error("udpfb_seq: IDX_W too narrow");
      end
   endgenerate

   seq_state_t       state_q;
   logic [IDX_W-1:0] idx_q, raw_len, flen;
   logic             in_hdr, in_pay;
   logic [5:0]       hsel;

   assign raw_len = IDX_W'(HDR_BYTES) + IDX_W'(plen);
   assign flen    = (raw_len < IDX_W'(MIN_FRAME)) ? IDX_W'(MIN_FRAME) : raw_len;
   assign in_hdr  = idx_q < IDX_W'(HDR_BYTES);
   assign in_pay  = !in_hdr && (idx_q < raw_len);
   assign hsel    = idx_q[5:0];
   assign rd_addr = in_pay ? CNT_W'(idx_q - IDX_W'(HDR_BYTES)) : '0;

   assign busy     = (state_q != SEQ_IDLE);
   assign calc_en  = (state_q == SEQ_CALC);
   assign tx_valid = (state_q == SEQ_STREAM);
   assign tx_last  = tx_valid && (idx_q == flen - 1'b1);
   assign tx_data  = !tx_valid ? 8'h00 : in_hdr ? hdr[hsel] : in_pay ? rd_data : 8'h00;
   assign done     = tx_valid && tx_ready && tx_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               idx_q <= '0;
               if (send) state_q <= SEQ_CALC;
            end
            SEQ_CALC: state_q <= SEQ_STREAM;
            SEQ_STREAM: begin
               if (tx_ready) begin
                  if (tx_last) state_q <= SEQ_IDLE;
                  else         idx_q   <= idx_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
   p_last_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> !tx_valid);
   p_frame_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> idx_q >= IDX_W'(MIN_FRAME - 1));
endmodule

// File: rtl/udp_frame_builder.sv
module udp_frame_builder
   import udpfb_pkg::*;
#(
   parameter int MAX_PAYLOAD = 1472,
   parameter int MIN_FRAME   = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        app_valid,
   input  logic [7:0]  app_data,
   input  logic        send,
   input  logic [47:0] cfg_dst_mac,
   input  logic [31:0] cfg_src_ip,
   input  logic [31:0] cfg_dst_ip,
   input  logic        tx_ready,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        tx_last,
   output logic        busy,
   output logic        ovf
);
   localparam int CNT_W     = $clog2(MAX_PAYLOAD + 1);
   localparam int FRAME_MAX = (HDR_BYTES + MAX_PAYLOAD > MIN_FRAME) ? HDR_BYTES + MAX_PAYLOAD : MIN_FRAME;
   localparam int IDX_W     = $clog2(FRAME_MAX + 1);

   logic [CNT_W-1:0] count, rd_addr;
   logic [7:0]       rd_data;
   logic             calc_en, done, busy_i;
   logic [47:0]      mac_q;
   logic [31:0]      sip_q, dip_q;
   hdr_bytes_t       hdr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mac_q <= '0;
         sip_q <= '0;
         dip_q <= '0;
      end else if (send && !busy_i) begin
         mac_q <= cfg_dst_mac;
         sip_q <= cfg_src_ip;
         dip_q <= cfg_dst_ip;
      end
   end

   udpfb_buf #(.MAX_PAYLOAD(MAX_PAYLOAD), .CNT_W(CNT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .app_valid(app_valid), .app_data(app_data),
      .block(busy_i || send), .clr(done), .rd_addr(rd_addr),
      .count(count), .ovf(ovf), .rd_data(rd_data));

   udpfb_hdr #(.CNT_W(CNT_W)) u_hdr (
      .clk(clk), .rst_n(rst_n), .calc_en(calc_en), .clr(done), .plen(count),
      .dst_mac(mac_q), .src_ip(sip_q), .dst_ip(dip_q), .hdr(hdr));

   udpfb_seq #(.MAX_PAYLOAD(MAX_PAYLOAD), .MIN_FRAME(MIN_FRAME), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .send(send), .plen(count), .hdr(hdr), .rd_data(rd_data),
      .tx_ready(tx_ready), .busy(busy_i), .calc_en(calc_en), .done(done), .rd_addr(rd_addr),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last));

   assign busy = busy_i;
endmodule

// File: tb/udp_frame_builder_bench.sv
module udp_frame_builder_bench;
   localparam int MAXP = 30;
   localparam int MINF = 64;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0, app_valid = 1'b0, send = 1'b0, tx_ready = 1'b1;
   logic [7:0]  app_data = '0;
   logic [47:0] cfg_dst_mac = '0;
   logic [31:0] cfg_src_ip = '0, cfg_dst_ip = '0;
   logic        tx_valid, tx_last, busy, ovf;
   logic [7:0]  tx_data;

   udp_frame_builder #(.MAX_PAYLOAD(MAXP), .MIN_FRAME(MINF)) u_udp_frame_builder (
      .clk(clk), .rst_n(rst_n), .app_valid(app_valid), .app_data(app_data), .send(send),
      .cfg_dst_mac(cfg_dst_mac), .cfg_src_ip(cfg_src_ip), .cfg_dst_ip(cfg_dst_ip),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .busy(busy), .ovf(ovf));

   int          n_cmp = 0, n_bad = 0;
   logic [8:0]  exp_q [$];
   string       tag_q [$];
   logic [7:0]  pl_q [$];
   logic [47:0] m_mac;
   logic [31:0] m_sip, m_dip;
   bit          stall_mode = 0;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   function automatic string tag_of(input int i, input int l);
      if (i >= 42) return (i < 42 + l) ? "R5" : "R6";
      if (i < 6 || (i >= 26 && i < 34)) return "R2";
      if (i == 16 || i == 17 || i == 38 || i == 39) return "R3";
      if (i == 24 || i == 25) return "R4";
      return "R1";
   endfunction

   task automatic push_frame();
      logic [7:0] hb [42];
      int l, flen, s;
      l = pl_q.size();
      flen = (42 + l < MINF) ? MINF : 42 + l;
      for (int i = 0; i < 42; i++) hb[i] = 8'h00;
      for (int i = 0; i < 6; i++) hb[i] = m_mac[47-8*i -: 8];
      hb[6] = 8'h02; hb[9] = 8'hC0; hb[10] = 8'hFF; hb[11] = 8'hEE;
      hb[12] = 8'h08; hb[14] = 8'h45;
      hb[16] = 8'((28 + l) >> 8); hb[17] = 8'(28 + l);
      hb[20] = 8'h40; hb[22] = 8'h40; hb[23] = 8'h11;
      for (int i = 0; i < 4; i++) begin
         hb[26+i] = m_sip[31-8*i -: 8];
         hb[30+i] = m_dip[31-8*i -: 8];
      end
      hb[34] = 8'h1A; hb[35] = 8'h0B; hb[36] = 8'h1A; hb[37] = 8'h0A;
      hb[38] = 8'((8 + l) >> 8); hb[39] = 8'(8 + l);
      s = 0;
      for (int i = 14; i < 34; i += 2) s += {hb[i], hb[i+1]};
      while (s > 16'hFFFF) s = (s & 16'hFFFF) + (s >> 16);
      s = ~s & 16'hFFFF;
      hb[24] = 8'(s >> 8); hb[25] = 8'(s);
      for (int i = 0; i < flen; i++) begin
         logic [7:0] b;
         b = (i < 42) ? hb[i] : (i < 42 + l) ? pl_q[i-42] : 8'h00;
         exp_q.push_back({(i == flen - 1), b});
         tag_q.push_back(tag_of(i, l));
      end
      pl_q.delete();
   endtask

   task automatic append_n(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         app_valid = 1'b1;
         app_data  = 8'(base + 7 * i);
         if (pl_q.size() < MAXP) pl_q.push_back(8'(base + 7 * i));
      end
      @(negedge clk);
      app_valid = 1'b0;
   endtask

   task automatic set_cfg(input logic [47:0] mac, input logic [31:0] sip, input logic [31:0] dip);
      cfg_dst_mac = mac; cfg_src_ip = sip; cfg_dst_ip = dip;
      m_mac = mac; m_sip = sip; m_dip = dip;
   endtask

   task automatic pulse_send();
      push_frame();
      @(negedge clk);
      send = 1'b1;
      @(negedge clk);
      send = 1'b0;
   endtask

   task automatic wait_done();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(busy == 1'b0, "R10", "busy after last byte", busy, 0);
      chk(ovf == 1'b0, "R10", "ovf after frame", ovf, 0);
   endtask

   // Monitor: drive tx_ready, then sample the handshake mid-cycle.
   initial begin
      int cyc;
      logic [8:0] e;
      string t;
      cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         tx_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
         #1;
         if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8", "unexpected byte", tx_data, 0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(tx_data == e[7:0], t, "frame byte", tx_data, e[7:0]);
               chk(tx_last == e[8], "R7", "last flag", tx_last, e[8]);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      set_cfg(48'h0200_0000_0001, 32'h7F00_0001, 32'hFFFF_FFFF);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(tx_valid == 1'b0, "R11", "tx_valid after reset", tx_valid, 0);
      chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
      chk(ovf == 1'b0, "R11", "ovf after reset", ovf, 0);

      // Empty payload: padded minimum frame (R6, R1, R3, R4).
      pulse_send();
      wait_done();

      // Short payload under backpressure (R7, R5).
      set_cfg(48'hA1B2_C3D4_E5F6, 32'hC0A8_0102, 32'h0A00_00FE);
      stall_mode = 1;
      append_n(5, 8'h31);
      pulse_send();
      wait_done();
      stall_mode = 0;

      // Full payload plus two extra appends (R9), frame above minimum.
      append_n(MAXP + 2, 8'h80);
      chk(ovf == 1'b1, "R9", "ovf after excess appends", ovf, 1);
      pulse_send();
      chk(ovf == 1'b1, "R9", "ovf held during frame", ovf, 1);
      wait_done();

      // Appends, sends and config changes while busy (R8, R2).
      set_cfg(48'h0011_2233_4455, 32'h0101_0101, 32'h0202_0202);
      append_n(3, 8'h10);
      pulse_send();
      cfg_dst_mac = 48'hDEAD_BEEF_0000;
      cfg_src_ip  = 32'h0909_0909;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         app_valid = 1'b1;
         app_data  = 8'hAA;
         send      = (i == 2);
      end
      @(negedge clk);
      app_valid = 1'b0;
      send      = 1'b0;
      wait_done();
      repeat (20) @(negedge clk);
      chk(tx_valid == 1'b0, "R8", "no frame from send while busy", tx_valid, 0);
      m_mac = cfg_dst_mac; m_sip = cfg_src_ip;
      pulse_send();
      wait_done();

      // Append in the same cycle as send is dropped (R8).
      append_n(2, 8'h55);
      push_frame();
      @(negedge clk);
      app_valid = 1'b1; app_data = 8'hEE; send = 1'b1;
      @(negedge clk);
      app_valid = 1'b0; send = 1'b0;
      wait_done();

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "expected queue drained", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule